// File: doc/BRIEF.md
# Segment Access Protection Checker

This block validates one memory access against a segment descriptor that is already cached in the pipeline. Each cycle it can take one request. The request carries the descriptor fields and the access to be checked:

- Descriptor fields: base, 20-bit limit, granularity, default-size flag, present flag, memory/system flag, descriptor privilege level and the 4-bit type.
- Access fields: offset, length, kind (read, write or execute), the current privilege level and the requested privilege level.

One clock later the block returns a registered response. The response holds the 32-bit linear address, a pass flag, a fault cause and a request to set the descriptor's accessed bit.

The limit check scales the raw limit by the granularity flag. For expand-down data segments the valid range is reversed: it lies above the limit and ends at an upper bound chosen by the default-size flag. The permission check reads the type field. The privilege check uses the weaker of the current and requested levels. When several checks fail, a fixed priority picks the one cause that is reported.

Top module: `seg_access_check`

## Requirements
- R1: A request presented with `req_valid` high on a rising edge gives `rsp_valid` high after that edge. After an edge with `req_valid` low, `rsp_valid`, `acc_ok`, `set_accessed`, `fault_cause` and `lin_addr` are all zero. Synchronous reset drives the same all-zero state.
- R2: `lin_addr` equals `desc_base + acc_offset` modulo 2^32, whether the access passes or faults.
- R3: With `desc_gran`=0 the effective limit is the 20-bit limit in bytes. With `desc_gran`=1 it is limit*4096+4095.
- R4: Type bit 3 selects code (1) or data (0). For code segments, and for data segments with type bit 2 clear (expand-up), the last byte `acc_offset + acc_len_m1` must be no greater than the effective limit. The sum is computed without wrapping, so a last byte beyond 2^32-1 fails. `acc_len_m1` is the access length in bytes minus one.
- R5: A data segment with type bit 2 set is expand-down. It passes only if `acc_offset` is greater than the effective limit and the last byte is no greater than 0xFFFF when `desc_big`=0, or no greater than 0xFFFFFFFF when `desc_big`=1.
- R6: Access kind codes are read=0, write=1, execute=2; code 3 always gives a permission fault. A data segment allows read, allows write only when type bit 1 is set, and never allows execute. A code segment allows execute, allows read only when type bit 1 is set, and never allows write.
- R7: With effective level max(`cur_pl`, `req_pl`), an access faults on privilege when that level is numerically greater than `desc_dpl`.
- R8: `desc_present`=0 on a memory descriptor gives a not-present fault.
- R9: `desc_is_mem`=0 (system descriptor) gives a system-type fault.
- R10: Fault codes are none=0, system-type=1, not-present=2, privilege=3, permission=4, limit=5. When several checks fail, the reported cause follows that same order: system-type wins over not-present, not-present over privilege, privilege over permission, and permission over limit. `acc_ok` is 1 exactly when the cause is none.
- R11: `set_accessed` is 1 exactly on a response that passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| desc_base | input | 32 | Segment base address |
| desc_limit | input | 20 | Raw segment limit |
| desc_gran | input | 1 | Limit unit: 0 bytes, 1 4 KB pages |
| desc_big | input | 1 | Expand-down upper bound: 0 for 0xFFFF, 1 for 0xFFFFFFFF |
| desc_present | input | 1 | Segment present in memory |
| desc_is_mem | input | 1 | 1 for a code/data descriptor, 0 for a system descriptor |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_type | input | 4 | Type field: bit 3 code, bit 2 expand-down/conforming, bit 1 writable/readable, bit 0 accessed |
| acc_offset | input | 32 | Offset of the first byte |
| acc_len_m1 | input | 3 | Access length in bytes minus one |
| acc_kind | input | 2 | 0 read, 1 write, 2 execute |
| cur_pl | input | 2 | Current privilege level |
| req_pl | input | 2 | Requested privilege level |
| rsp_valid | output | 1 | Response present |
| lin_addr | output | 32 | Linear address |
| acc_ok | output | 1 | Access passes every check |
| fault_cause | output | 3 | Fault code per R10 |
| set_accessed | output | 1 | Request to set the accessed bit |

## Verification
The assertions assume that the request fields are stable and known on every edge where `req_valid` is high. They also assume reset is held for at least one edge before the first request. The bench drives inputs only on falling edges, so every field is settled before the rising edge samples it. The random stimulus is biased towards present memory descriptors with permissive privilege and towards offsets near the effective limit, so that both passing and limit-fault responses occur often. Idle cycles are mixed into the stream so the all-zero response is also exercised.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    localparam int ADDR_W     = 32;
    localparam int LIMIT_W    = 20;
    localparam int GRAN_SHIFT = 12;
    localparam int LEN_W      = 3;
    localparam int PL_W       = 2;
    localparam int TYPE_W     = 4;

    // type field bit positions (decoded by the permission and limit logic)
    localparam int TB_CODE = 3;
    localparam int TB_DIR  = 2;
    localparam int TB_RW   = 1;

    typedef enum logic [1:0] {
        KIND_READ  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_EXEC  = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_SYSTYPE = 3'd1,
        FLT_ABSENT  = 3'd2,
        FLT_PRIV    = 3'd3,
        FLT_PERM    = 3'd4,
        FLT_LIMIT   = 3'd5
    } fault_e;

    typedef struct packed {
        logic                base_dummy; // keeps struct non-empty if fields move
        logic                is_mem;
        logic                present;
        logic [PL_W-1:0]     dpl;
        logic [TYPE_W-1:0]   seg_type;
    } desc_attr_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lin;
        logic              ok;
        fault_e            cause;
    } chk_result_t;

    function automatic logic [PL_W-1:0] weaker_pl(input logic [PL_W-1:0] a,
                                                  input logic [PL_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // priority: system type, not present, privilege, permission, limit
    function automatic fault_e pick_fault(input logic is_mem, input logic present,
                                          input logic priv_ok, input logic perm_ok,
                                          input logic range_ok);
        if (!is_mem)        return FLT_SYSTYPE;
        else if (!present)  return FLT_ABSENT;
        else if (!priv_ok)  return FLT_PRIV;
        else if (!perm_ok)  return FLT_PERM;
        else if (!range_ok) return FLT_LIMIT;
        else                return FLT_NONE;
    endfunction

endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit
    import seg_chk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LW  = LIMIT_W,
    parameter int GS  = GRAN_SHIFT,
    parameter int LNW = LEN_W
) (
    input  logic [AW-1:0]  offset,
    input  logic [LNW-1:0] len_m1,
    input  logic [LW-1:0]  raw_limit,
    input  logic           gran,
    input  logic           big,
    input  logic           expand_down,
    output logic           in_range
);
    localparam int SMALL_TOP_W = 16;

    logic [AW-1:0] eff_limit;
    logic [AW-1:0] top_bound;
    logic [AW:0]   last_byte;
    logic          up_ok;
    logic          dn_ok;

    always_comb begin
        if (gran) eff_limit = AW'({raw_limit, {GS{1'b1}}});
        else      eff_limit = AW'(raw_limit);
        top_bound = big ? {AW{1'b1}} : AW'({SMALL_TOP_W{1'b1}});
        last_byte = {1'b0, offset} + (AW+1)'(len_m1);
        up_ok     = (last_byte <= {1'b0, eff_limit});
        dn_ok     = (offset > eff_limit) && (last_byte <= {1'b0, top_bound});
        in_range  = expand_down ? dn_ok : up_ok;
    end
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
    import seg_chk_pkg::*;
#(
    parameter int PLW = PL_W,
    parameter int TW  = TYPE_W
) (
    input  logic [TW-1:0]  seg_type,
    input  logic [1:0]     kind,
    input  logic [PLW-1:0] cur_pl,
    input  logic [PLW-1:0] req_pl,
    input  logic [PLW-1:0] dpl,
    output logic           perm_ok,
    output logic           priv_ok
);
    logic is_code;
    logic rw_bit;

    always_comb begin
        is_code = seg_type[TB_CODE];
        rw_bit  = seg_type[TB_RW];
        unique case (acc_kind_e'(kind))
            KIND_READ:  perm_ok = !is_code || rw_bit;
            KIND_WRITE: perm_ok = !is_code && rw_bit;
            KIND_EXEC:  perm_ok = is_code;
            default:    perm_ok = 1'b0;
        endcase
        priv_ok = (weaker_pl(cur_pl, req_pl) <= dpl);
    end
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
    import seg_chk_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int LW  = LIMIT_W,
    parameter int GS  = GRAN_SHIFT,
    parameter int LNW = LEN_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req_valid,
    input  logic [AW-1:0]  desc_base,
    input  logic [LW-1:0]  desc_limit,
    input  logic           desc_gran,
    input  logic           desc_big,
    input  logic           desc_present,
    input  logic           desc_is_mem,
    input  logic [1:0]     desc_dpl,
    input  logic [3:0]     desc_type,
    input  logic [AW-1:0]  acc_offset,
    input  logic [LNW-1:0] acc_len_m1,
    input  logic [1:0]     acc_kind,
    input  logic [1:0]     cur_pl,
    input  logic [1:0]     req_pl,
    output logic           rsp_valid,
    output logic [AW-1:0]  lin_addr,
    output logic           acc_ok,
    output logic [2:0]     fault_cause,
    output logic           set_accessed
);
    logic   range_ok, perm_ok, priv_ok, expand_down;
    fault_e cause_next;

    assign expand_down = !desc_type[TB_CODE] && desc_type[TB_DIR];

    seg_limit_unit #(.AW(AW), .LW(LW), .GS(GS), .LNW(LNW)) u_limit (
        .offset      (acc_offset),
        .len_m1      (acc_len_m1),
        .raw_limit   (desc_limit),
        .gran        (desc_gran),
        .big         (desc_big),
        .expand_down (expand_down),
        .in_range    (range_ok)
    );

    seg_rights_unit #(.PLW(2), .TW(4)) u_rights (
        .seg_type (desc_type),
        .kind     (acc_kind),
        .cur_pl   (cur_pl),
        .req_pl   (req_pl),
        .dpl      (desc_dpl),
        .perm_ok  (perm_ok),
        .priv_ok  (priv_ok)
    );

    assign cause_next = pick_fault(desc_is_mem, desc_present, priv_ok, perm_ok, range_ok);

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid    <= 1'b0;
            lin_addr     <= '0;
            acc_ok       <= 1'b0;
            fault_cause  <= FLT_NONE;
            set_accessed <= 1'b0;
        end else begin
            rsp_valid    <= 1'b1;
            lin_addr     <= desc_base + acc_offset;
            acc_ok       <= (cause_next == FLT_NONE);
            fault_cause  <= cause_next;
            set_accessed <= (cause_next == FLT_NONE);
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !acc_ok && !set_accessed));

    assert_lin_sum_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (lin_addr == $past(desc_base + acc_offset)));

    assert_code_never_written_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && desc_type[TB_CODE] && acc_kind == KIND_WRITE) |=> !acc_ok);

    assert_priv_block_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (cur_pl > desc_dpl || req_pl > desc_dpl)) |=> !acc_ok);

    assert_absent_cause_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && desc_is_mem && !desc_present) |=> (fault_cause == FLT_ABSENT));

    assert_system_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !desc_is_mem) |=> (fault_cause == FLT_SYSTYPE));

    assert_ok_no_cause_R10: assert property (@(posedge clk) disable iff (rst)
        acc_ok |-> (fault_cause == FLT_NONE && rsp_valid));

    assert_accessed_on_pass_R11: assert property (@(posedge clk) disable iff (rst)
        set_accessed |-> acc_ok);
endmodule

// File: tb/seg_access_check_bench.sv
module seg_access_check_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] desc_base = '0;
    logic [19:0] desc_limit = '0;
    logic        desc_gran = 1'b0, desc_big = 1'b0, desc_present = 1'b0, desc_is_mem = 1'b0;
    logic [1:0]  desc_dpl = '0;
    logic [3:0]  desc_type = '0;
    logic [31:0] acc_offset = '0;
    logic [2:0]  acc_len_m1 = '0;
    logic [1:0]  acc_kind = '0, cur_pl = '0, req_pl = '0;
    logic        rsp_valid, acc_ok, set_accessed;
    logic [31:0] lin_addr;
    logic [2:0]  fault_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_access_check u_seg_access_check (
        .clk, .rst, .req_valid, .desc_base, .desc_limit, .desc_gran, .desc_big,
        .desc_present, .desc_is_mem, .desc_dpl, .desc_type, .acc_offset,
        .acc_len_m1, .acc_kind, .cur_pl, .req_pl, .rsp_valid, .lin_addr,
        .acc_ok, .fault_cause, .set_accessed
    );

    task automatic check(input string tag, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
        end
    endtask

    // behavioural reference of the fault code
    function automatic int ref_cause();
        longint eff, last, top;
        int     epl;
        bit     perm, in_rng, is_code;
        if (!desc_is_mem)  return 1;
        if (!desc_present) return 2;
        epl = (cur_pl > req_pl) ? int'(cur_pl) : int'(req_pl);
        if (epl > int'(desc_dpl)) return 3;
        is_code = desc_type[3];
        case (acc_kind)
            2'd0:    perm = !is_code || desc_type[1];
            2'd1:    perm = !is_code && desc_type[1];
            2'd2:    perm = is_code;
            default: perm = 0;
        endcase
        if (!perm) return 4;
        eff  = desc_gran ? longint'(desc_limit) * 4096 + 4095 : longint'(desc_limit);
        last = longint'(acc_offset) + longint'(acc_len_m1);
        top  = desc_big ? 64'hFFFF_FFFF : 64'hFFFF;
        if (!is_code && desc_type[2]) in_rng = (longint'(acc_offset) > eff) && (last <= top);
        else                          in_rng = (last <= eff);
        return in_rng ? 0 : 5;
    endfunction

    // inputs are set at a falling edge; result is registered at the next rising edge
    task automatic apply(input string tag);
        int          ec;
        logic [31:0] ea;
        string       t;
        ec = ref_cause();
        ea = desc_base + acc_offset;
        if (tag != "") t = tag;
        else begin
            case (ec)
                0: t = "R3 pass";
                1: t = "R9";
                2: t = "R8";
                3: t = "R7";
                4: t = "R6";
                default: t = (!desc_type[3] && desc_type[2]) ? "R5" : "R4";
            endcase
        end
        @(negedge clk);
        check("R1 rsp_valid", longint'(rsp_valid), 1);
        check({t, " fault_cause"}, longint'(fault_cause), longint'(ec));
        check("R10 acc_ok", longint'(acc_ok), (ec == 0) ? 1 : 0);
        check("R11 set_accessed", longint'(set_accessed), (ec == 0) ? 1 : 0);
        check("R2 lin_addr", longint'(lin_addr), longint'(ea));
    endtask

    task automatic setup(input logic [31:0] base, input logic [19:0] lim, input bit g,
                         input bit b, input logic [3:0] typ, input logic [31:0] off,
                         input logic [2:0] lm1, input logic [1:0] kind);
        req_valid = 1; desc_base = base; desc_limit = lim; desc_gran = g; desc_big = b;
        desc_present = 1; desc_is_mem = 1; desc_dpl = 3; desc_type = typ;
        acc_offset = off; acc_len_m1 = lm1; acc_kind = kind; cur_pl = 0; req_pl = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rsp_valid", longint'(rsp_valid), 0);
        check("R1 reset acc_ok", longint'(acc_ok), 0);
        check("R1 reset set_accessed", longint'(set_accessed), 0);
        check("R1 reset lin_addr", longint'(lin_addr), 0);
        rst = 0;

        // R4 expand-up byte granularity, at and just past the limit
        setup(32'h7c00, 20'h001ff, 0, 1, 4'b1000, 32'h1ff, 0, 2); apply("R4 last byte");
        setup(32'h7c00, 20'h001ff, 0, 1, 4'b1000, 32'h1ff, 1, 2); apply("R4 over by one");
        // R3 page granularity
        setup(32'h0, 20'h0, 1, 1, 4'b0010, 32'hfff, 0, 1); apply("R3 page end");
        setup(32'h0, 20'h0, 1, 1, 4'b0010, 32'h1000, 0, 1); apply("R3 next page");
        setup(32'h0, 20'hfffff, 1, 1, 4'b0010, 32'hffff_ffff, 1, 0); apply("R4 no wrap");
        // R5 expand-down
        setup(32'h0, 20'h07a00, 0, 0, 4'b0110, 32'h7a00, 0, 1); apply("R5 at limit");
        setup(32'h0, 20'h07a00, 0, 0, 4'b0110, 32'h7a01, 0, 1); apply("R5 above limit");
        setup(32'h0, 20'h07a00, 0, 0, 4'b0110, 32'hfffe, 1, 1); apply("R5 small top");
        setup(32'h0, 20'h07a00, 0, 0, 4'b0110, 32'hffff, 1, 1); apply("R5 past small top");
        setup(32'h0, 20'h07a00, 0, 1, 4'b0110, 32'hffff, 1, 1); apply("R5 big top");
        setup(32'h0, 20'h07a00, 0, 1, 4'b0110, 32'hffff_fffc, 3, 0); apply("R5 big top end");
        // R2 address wrap
        setup(32'hffff_fff0, 20'hfffff, 1, 1, 4'b0010, 32'h20, 0, 0); apply("R2 wrap");
        // R6 permissions
        setup(32'h0, 20'hfffff, 0, 1, 4'b1010, 32'h10, 0, 1); apply("R6 code write");
        setup(32'h0, 20'hfffff, 0, 1, 4'b1000, 32'h10, 0, 0); apply("R6 code read R=0");
        setup(32'h0, 20'hfffff, 0, 1, 4'b1010, 32'h10, 0, 0); apply("R6 code read R=1");
        setup(32'h0, 20'hfffff, 0, 1, 4'b0010, 32'h10, 0, 2); apply("R6 data exec");
        setup(32'h0, 20'hfffff, 0, 1, 4'b0000, 32'h10, 0, 1); apply("R6 data ro write");
        setup(32'h0, 20'hfffff, 0, 1, 4'b0010, 32'h10, 0, 3); apply("R6 kind 3");
        // R7 privilege
        setup(32'h0, 20'hfffff, 0, 1, 4'b0010, 32'h10, 0, 0);
        desc_dpl = 2; cur_pl = 0; req_pl = 3; apply("R7 rpl weaker");
        setup(32'h0, 20'hfffff, 0, 1, 4'b0010, 32'h10, 0, 0);
        desc_dpl = 2; cur_pl = 2; req_pl = 1; apply("R7 equal level");
        // R8, R9, R10 priority
        setup(32'h0, 20'hfffff, 0, 1, 4'b0010, 32'h10, 0, 0);
        desc_present = 0; apply("R8 absent");
        setup(32'h0, 20'h0, 0, 1, 4'b1010, 32'h10, 0, 1);
        desc_is_mem = 0; desc_present = 0; desc_dpl = 0; cur_pl = 3; apply("R10 system first");
        setup(32'h0, 20'h0, 0, 1, 4'b1010, 32'h10, 0, 1);
        desc_present = 0; desc_dpl = 0; cur_pl = 3; apply("R10 absent before priv");
        setup(32'h0, 20'h0, 0, 1, 4'b1010, 32'h10, 0, 1);
        desc_dpl = 0; cur_pl = 3; apply("R10 priv before perm");
        setup(32'h0, 20'h0, 0, 1, 4'b1010, 32'h10, 0, 1); apply("R10 perm before limit");

        // R1 idle cycle
        req_valid = 0;
        @(negedge clk);
        check("R1 idle rsp_valid", longint'(rsp_valid), 0);
        check("R1 idle acc_ok", longint'(acc_ok), 0);
        check("R1 idle set_accessed", longint'(set_accessed), 0);
        check("R1 idle fault_cause", longint'(fault_cause), 0);
        check("R1 idle lin_addr", longint'(lin_addr), 0);

        // biased random stream
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] eff;
            setup($urandom, 20'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                  32'h0, 3'($urandom), 2'($urandom_range(0, 2)));
            desc_is_mem  = ($urandom_range(0, 15) != 0);
            desc_present = ($urandom_range(0, 15) != 0);
            desc_dpl     = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'd3;
            cur_pl       = 2'($urandom);
            req_pl       = 2'($urandom);
            eff = desc_gran ? {desc_limit, 12'hfff} : {12'h0, desc_limit};
            case ($urandom_range(0, 3))
                0:       acc_offset = eff - 32'($urandom_range(0, 8));
                1:       acc_offset = eff + 32'($urandom_range(0, 8));
                2:       acc_offset = 32'hffff - 32'($urandom_range(0, 8));
                default: acc_offset = $urandom;
            endcase
            if ($urandom_range(0, 9) == 0) begin
                req_valid = 0;
                @(negedge clk);
                check("R1 idle rsp_valid", longint'(rsp_valid), 0);
                check("R1 idle set_accessed", longint'(set_accessed), 0);
                req_valid = 1;
            end
            apply("");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule